// File: doc/BRIEF.md
# Display Control Register Unit

This block holds the display status word and the geometry registers of a raster display controller. Software writes 32-bit control words on a control port. The top byte of each word is a command code. The command code selects which field of the status word or which geometry register the low bits update. The block turns the packed mode bits of the status word into the active pixel width and line count through two fixed tables. It also keeps an odd/even field flag that moves on each vertical-blank start.

A second write port takes drawing-mode words from the command parser, which update the low drawing-control fields of the status word. The status word is read combinationally from its register. Every control word whose command code lies within a small shadow range is also kept raw in a shadow bank, which can be read back by index. Video timing, scan-out and colour conversion belong to other blocks.

Top module: `disp_ctrl_regs`

## Requirements
- R1: While reset is asserted and after it is released, the status word reads 0x14802000 and every geometry and shadow register reads 0. Control command 0x00 sets the status word back to 0x14802000 and leaves the geometry and shadow registers as they are.
- R2: Control command 0x03 copies data bit 0 into status bit 23, the display-off flag, and changes no other status bit.
- R3: Control command 0x04 copies data bits 1:0 into status bits 30:29, the transfer-direction field.
- R4: Control command 0x05 loads the display start X from data bits 9:0 and the start Y from data bits 19:10.
- R5: Control command 0x07 loads the first visible line from data bits 9:0 and the last visible line from data bits 19:10.
- R6: Control command 0x08 writes status bits 22:16: data bit 6 goes to bit 16 and data bits 5:0 go to bits 22:17. Bit 22 is the interlace enable.
- R7: The pixel width output follows status bits 18:16 through the table 0→256, 1→368, 2→320, 3→384, 4→512, 5→512, 6→640, 7→640.
- R8: The line count output follows status bits 20:19 through the table 0→240, 1→480, 2→256, 3→480.
- R9: Every control word with a command code below 16 is stored whole in shadow entry number <code>, and shadow_word returns the entry chosen by shadow_sel. Command codes of 16 and above change no register. Codes below 16 other than 0, 3, 4, 5, 7 and 8 change only the shadow bank.
- R10: On a cycle with vblank_start high, status bit 31 (also driven on field_odd) inverts if interlace is enabled and clears if it is not. On any other cycle it holds, unless command 0x00 clears it.
- R11: A drawing-mode word with top byte 0xE1 replaces status bits 10:0 with its bits 10:0. One with top byte 0xE6 writes its bits 1:0 into status bits 12:11. Any other top byte on that port has no effect.
- R12: When several writes arrive in one cycle, they apply in this order: the control word first, then the drawing-mode word, then the vertical-blank step. The vertical-blank step reads the interlace bit as the control word left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word valid |
| ctl_word | input | 32 | Control word, command in bits 31:24 |
| draw_we | input | 1 | Drawing-mode word valid |
| draw_word | input | 32 | Drawing-mode word, opcode in bits 31:24 |
| vblank_start | input | 1 | One-cycle pulse at vertical-blank start |
| shadow_sel | input | 4 | Shadow entry to read |
| status_word | output | 32 | Current status word |
| start_x | output | 10 | Display start X |
| start_y | output | 10 | Display start Y |
| vrange_lo | output | 10 | First visible line |
| vrange_hi | output | 10 | Last visible line |
| hres | output | 10 | Active pixel width |
| vres | output | 9 | Active line count |
| field_odd | output | 1 | Odd/even field flag |
| shadow_word | output | 32 | Selected shadow entry |

## Verification
The hardest case to reach is a long run of field toggles. It needs the interlace bit to be set through a command 0x08 word with data bit 5 high, and it must then stay set across many vertical-blank pulses. Random command streams keep clearing it or resetting the status word. Directed sequences therefore set interlace, pulse vblank_start several times in a row, and then clear it in the same cycle as a pulse. The random phase also puts control, drawing and vblank writes in the same cycle, to exercise the ordering in R12.

// File: rtl/disp_ctrl_pkg.sv
package disp_ctrl_pkg;
  localparam logic [31:0] STATUS_RST = 32'h1480_2000;

  localparam logic [7:0] OP_RESET  = 8'h00;
  localparam logic [7:0] OP_BLANK  = 8'h03;
  localparam logic [7:0] OP_XFER   = 8'h04;
  localparam logic [7:0] OP_START  = 8'h05;
  localparam logic [7:0] OP_VRANGE = 8'h07;
  localparam logic [7:0] OP_MODE   = 8'h08;
  localparam logic [7:0] OP_TPAGE  = 8'hE1;
  localparam logic [7:0] OP_MASK   = 8'hE6;

  localparam int BIT_FIELD  = 31;
  localparam int BIT_ILACE  = 22;
  localparam int BIT_BLANK  = 23;

  function automatic logic [9:0] width_of(input logic [2:0] code);
    case (code)
      3'd0:       width_of = 10'd256;
      3'd1:       width_of = 10'd368;
      3'd2:       width_of = 10'd320;
      3'd3:       width_of = 10'd384;
      3'd4, 3'd5: width_of = 10'd512;
      default:    width_of = 10'd640;
    endcase
  endfunction

  function automatic logic [8:0] lines_of(input logic [1:0] code);
    case (code)
      2'd0:    lines_of = 9'd240;
      2'd2:    lines_of = 9'd256;
      default: lines_of = 9'd480;
    endcase
  endfunction
endpackage

// File: rtl/disp_status_reg.sv
module disp_status_reg
  import disp_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_word,
  input  logic        draw_we,
  input  logic [31:0] draw_word,
  input  logic        vblank_start,
  output logic [31:0] status_q
);
  logic [31:0] status_d;
  logic        status_en;
  logic [7:0]  ctl_op;
  logic [7:0]  draw_op;

  assign ctl_op    = ctl_word[31:24];
  assign draw_op   = draw_word[31:24];
  assign status_en = ctl_we | draw_we | vblank_start;

  always_comb begin
    status_d = status_q;
    if (ctl_we) begin
      case (ctl_op)
        OP_RESET: status_d = STATUS_RST;
        OP_BLANK: status_d[BIT_BLANK] = ctl_word[0];
        OP_XFER:  status_d[30:29] = ctl_word[1:0];
        OP_MODE:  status_d[22:16] = {ctl_word[5:0], ctl_word[6]};
        default:  ;
      endcase
    end
    if (draw_we) begin
      case (draw_op)
        OP_TPAGE: status_d[10:0]  = draw_word[10:0];
        OP_MASK:  status_d[12:11] = draw_word[1:0];
        default:  ;
      endcase
    end
    if (vblank_start) begin
      status_d[BIT_FIELD] = status_d[BIT_ILACE] ? ~status_d[BIT_FIELD] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= STATUS_RST;
    else if (status_en) status_q <= status_d;
  end
endmodule

// File: rtl/disp_geom_regs.sv
module disp_geom_regs
  import disp_ctrl_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [31:0]        ctl_word,
  output logic [COORD_W-1:0] start_x,
  output logic [COORD_W-1:0] start_y,
  output logic [COORD_W-1:0] vrange_lo,
  output logic [COORD_W-1:0] vrange_hi
);
  localparam int HI_LSB = COORD_W;
  localparam int HI_MSB = 2 * COORD_W - 1;

  logic start_en;
  logic range_en;
  logic [COORD_W-1:0] start_x_d, start_y_d, lo_d, hi_d;

  assign start_en = ctl_we && (ctl_word[31:24] == OP_START);
  assign range_en = ctl_we && (ctl_word[31:24] == OP_VRANGE);

  always_comb begin
    start_x_d = ctl_word[COORD_W-1:0];
    start_y_d = ctl_word[HI_MSB:HI_LSB];
    lo_d      = ctl_word[COORD_W-1:0];
    hi_d      = ctl_word[HI_MSB:HI_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_x <= '0;
      start_y <= '0;
    end else if (start_en) begin
      start_x <= start_x_d;
      start_y <= start_y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vrange_lo <= '0;
      vrange_hi <= '0;
    end else if (range_en) begin
      vrange_lo <= lo_d;
      vrange_hi <= hi_d;
    end
  end
endmodule

// File: rtl/disp_shadow_bank.sv
module disp_shadow_bank #(
  parameter int SHADOW_N = 16,
  parameter int WORD_W   = 32,
  localparam int IDX_W   = $clog2(SHADOW_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_word
);
  localparam int CODE_LSB = WORD_W - 8;

  logic [7:0]        code;
  logic              in_range;
  logic [WORD_W-1:0] entry_q [SHADOW_N];

  assign code     = ctl_word[WORD_W-1:CODE_LSB];
  assign in_range = (32'(code) < SHADOW_N);

  for (genvar gi = 0; gi < SHADOW_N; gi++) begin : g_entry
    logic hit;
    assign hit = ctl_we && in_range && (32'(code) == gi);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[gi] <= '0;
      else if (hit) entry_q[gi] <= ctl_word;
    end
  end

  assign rd_word = entry_q[rd_sel];
endmodule

// File: rtl/disp_res_lut.sv
module disp_res_lut
  import disp_ctrl_pkg::*;
(
  input  logic [31:0] status_word,
  output logic [9:0]  hres,
  output logic [8:0]  vres
);
  always_comb begin
    hres = width_of(status_word[18:16]);
    vres = lines_of(status_word[20:19]);
  end
endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import disp_ctrl_pkg::*;
#(
  parameter int COORD_W  = 10,
  parameter int SHADOW_N = 16,
  localparam int IDX_W   = $clog2(SHADOW_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [31:0]        ctl_word,
  input  logic               draw_we,
  input  logic [31:0]        draw_word,
  input  logic               vblank_start,
  input  logic [IDX_W-1:0]   shadow_sel,
  output logic [31:0]        status_word,
  output logic [COORD_W-1:0] start_x,
  output logic [COORD_W-1:0] start_y,
  output logic [COORD_W-1:0] vrange_lo,
  output logic [COORD_W-1:0] vrange_hi,
  output logic [9:0]         hres,
  output logic [8:0]         vres,
  output logic               field_odd,
  output logic [31:0]        shadow_word
);
  disp_status_reg u_status (
    .clk, .rst_n, .ctl_we, .ctl_word, .draw_we, .draw_word, .vblank_start,
    .status_q (status_word)
  );

  disp_geom_regs #(.COORD_W(COORD_W)) u_geom (
    .clk, .rst_n, .ctl_we, .ctl_word,
    .start_x, .start_y, .vrange_lo, .vrange_hi
  );

  disp_shadow_bank #(.SHADOW_N(SHADOW_N), .WORD_W(32)) u_shadow (
    .clk, .rst_n, .ctl_we, .ctl_word,
    .rd_sel  (shadow_sel),
    .rd_word (shadow_word)
  );

  disp_res_lut u_lut (
    .status_word, .hres, .vres
  );

  assign field_odd = status_word[BIT_FIELD];
endmodule

// File: rtl/disp_ctrl_regs_chk.sv
module disp_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [31:0] ctl_word,
  input logic        draw_we,
  input logic [31:0] draw_word,
  input logic        vblank_start,
  input logic [31:0] status_word,
  input logic [9:0]  start_x,
  input logic [9:0]  vrange_hi,
  input logic [9:0]  hres,
  input logic [8:0]  vres,
  input logic        field_odd
);
  logic [7:0] cop, dop;
  assign cop = ctl_word[31:24];
  assign dop = draw_word[31:24];

  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && cop == 8'h00 && !draw_we && !vblank_start) |=> status_word == 32'h1480_2000); // R1
  AST_BLANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && cop == 8'h03) |=> status_word[23] == $past(ctl_word[0])); // R2
  AST_XFER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && cop == 8'h04) |=> status_word[30:29] == $past(ctl_word[1:0])); // R3
  AST_START_X: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && cop == 8'h05) |=> start_x == $past(ctl_word[9:0])); // R4
  AST_RANGE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && cop == 8'h07) |=> vrange_hi == $past(ctl_word[19:10])); // R5
  AST_MODE_ILACE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && cop == 8'h08) |=> status_word[22] == $past(ctl_word[5])); // R6
  AST_WIDTH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[18:16] == 3'd0) |-> hres == 10'd256); // R7
  AST_LINES_PAL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[20:19] == 2'd2) |-> vres == 9'd256); // R8
  AST_FIELD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && !ctl_we && status_word[22]) |=> field_odd != $past(field_odd)); // R10
  AST_FIELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && !ctl_we && !status_word[22]) |=> !field_odd); // R10
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vblank_start && !(ctl_we && cop == 8'h00)) |=> $stable(field_odd)); // R10
  AST_MASK_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_we && dop == 8'hE6 && !(ctl_we && cop == 8'h00)) |=> status_word[12:11] == $past(draw_word[1:0])); // R11
  AST_ORDER_CTL_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && cop == 8'h00 && draw_we && dop == 8'hE1) |=> status_word[10:0] == $past(draw_word[10:0])); // R12
endmodule

bind disp_ctrl_regs disp_ctrl_regs_chk u_chk (
  .clk (clk), .rst_n (rst_n), .ctl_we (ctl_we), .ctl_word (ctl_word),
  .draw_we (draw_we), .draw_word (draw_word), .vblank_start (vblank_start),
  .status_word (status_word), .start_x (start_x), .vrange_hi (vrange_hi),
  .hres (hres), .vres (vres), .field_odd (field_odd)
);

// File: tb/disp_ctrl_regs_bench.sv
module disp_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we, draw_we, vblank_start;
  logic [31:0] ctl_word, draw_word;
  logic [3:0]  shadow_sel;
  logic [31:0] status_word, shadow_word;
  logic [9:0]  start_x, start_y, vrange_lo, vrange_hi, hres;
  logic [8:0]  vres;
  logic        field_odd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_status;
  logic [9:0]  m_sx, m_sy, m_lo, m_hi;
  logic [31:0] m_shadow [16];

  always #2.5 clk = ~clk;

  disp_ctrl_regs u_disp_ctrl_regs (
    .clk, .rst_n, .ctl_we, .ctl_word, .draw_we, .draw_word, .vblank_start,
    .shadow_sel, .status_word, .start_x, .start_y, .vrange_lo, .vrange_hi,
    .hres, .vres, .field_odd, .shadow_word
  );

  function automatic logic [9:0] exp_width(input logic [2:0] c);
    logic [9:0] t [8] = '{10'd256, 10'd368, 10'd320, 10'd384, 10'd512, 10'd512, 10'd640, 10'd640};
    return t[c];
  endfunction

  function automatic logic [8:0] exp_lines(input logic [1:0] c);
    logic [8:0] t [4] = '{9'd240, 9'd480, 9'd256, 9'd480};
    return t[c];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 R3 R6 R10 R11 R12 status", status_word, m_status);
    chk("R4 start_x", 32'(start_x), 32'(m_sx));
    chk("R4 start_y", 32'(start_y), 32'(m_sy));
    chk("R5 vrange_lo", 32'(vrange_lo), 32'(m_lo));
    chk("R5 vrange_hi", 32'(vrange_hi), 32'(m_hi));
    chk("R7 hres", 32'(hres), 32'(exp_width(m_status[18:16])));
    chk("R8 vres", 32'(vres), 32'(exp_lines(m_status[20:19])));
    chk("R10 field_odd", 32'(field_odd), 32'(m_status[31]));
    chk("R9 shadow", shadow_word, m_shadow[shadow_sel]);
  endtask

  // Model update from the requirements, applied in the R12 order.
  task automatic model_step();
    logic [31:0] s;
    s = m_status;
    if (ctl_we) begin
      case (ctl_word[31:24])
        8'h00: s = 32'h1480_2000;                              // R1
        8'h03: s[23] = ctl_word[0];                            // R2
        8'h04: s[30:29] = ctl_word[1:0];                       // R3
        8'h05: begin m_sx = ctl_word[9:0]; m_sy = ctl_word[19:10]; end // R4
        8'h07: begin m_lo = ctl_word[9:0]; m_hi = ctl_word[19:10]; end // R5
        8'h08: begin s[16] = ctl_word[6]; s[22:17] = ctl_word[5:0]; end // R6
        default: ;
      endcase
      if (ctl_word[31:24] < 8'd16) m_shadow[ctl_word[27:24]] = ctl_word; // R9
    end
    if (draw_we) begin
      if (draw_word[31:24] == 8'hE1) s[10:0] = draw_word[10:0];  // R11
      if (draw_word[31:24] == 8'hE6) s[12:11] = draw_word[1:0];
    end
    if (vblank_start) s[31] = s[22] ? ~s[31] : 1'b0;             // R10
    m_status = s;
  endtask

  task automatic cycle(input logic cw, input logic [31:0] cd, input logic dw,
                       input logic [31:0] dd, input logic vb, input logic [3:0] sel);
    ctl_we = cw; ctl_word = cd; draw_we = dw; draw_word = dd;
    vblank_start = vb; shadow_sel = sel;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst_n = 1'b0;
    ctl_we = 0; ctl_word = 0; draw_we = 0; draw_word = 0; vblank_start = 0; shadow_sel = 0;
    m_status = 32'h1480_2000;
    m_sx = 0; m_sy = 0; m_lo = 0; m_hi = 0;
    for (int i = 0; i < 16; i++) m_shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status_word, 32'h1480_2000);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(); // R1 after release

    // Directed: geometry, mode, tables
    cycle(1, 32'h0500_0000 | (10'd300 << 10) | 10'd17, 0, 0, 0, 4'd5);
    cycle(1, 32'h0700_0000 | (10'd258 << 10) | 10'd16, 0, 0, 0, 4'd7);
    for (int c = 0; c < 32; c++) begin
      cycle(1, 32'h0800_0000 | 32'((c[1:0] << 1) | (c[4] << 6) | (c[3:2] << 2)), 0, 0, 0, 4'd8); // R7 R8
    end
    // Directed: interlace toggling over several blanks, then clear on a blank
    cycle(1, 32'h0800_0020, 0, 0, 0, 4'd8);
    for (int k = 0; k < 5; k++) cycle(0, 0, 0, 0, 1, 4'd0);     // R10 toggles
    cycle(0, 0, 0, 0, 0, 4'd0);                                   // R10 hold
    cycle(1, 32'h0800_0000, 0, 0, 1, 4'd8);                       // R12 clear sees new interlace
    // Directed: reset command with drawing update in same cycle
    cycle(1, 32'h0300_0001, 0, 0, 0, 4'd3);
    cycle(1, 32'h0000_0000, 1, 32'hE100_07FF, 0, 4'd0);           // R12 R1
    cycle(0, 0, 1, 32'hE600_0003, 0, 4'd0);                       // R11
    cycle(0, 0, 1, 32'hE200_FFFF, 0, 4'd0);                       // R11 ignored opcode
    cycle(1, 32'h1500_03FF, 0, 0, 0, 4'd5);                       // R9 code>=16 no effect
    cycle(1, 32'h0A12_3456, 0, 0, 0, 4'd10);                      // R9 shadow-only code

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] cd, dd;
      logic [7:0]  op;
      int unsigned pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: op = 8'h00; 1: op = 8'h03; 2: op = 8'h04; 3: op = 8'h05;
        4: op = 8'h07; 5, 6: op = 8'h08; 7: op = 8'($urandom_range(0, 15));
        default: op = 8'($urandom);
      endcase
      cd = {op, 24'($urandom)};
      pick = $urandom_range(0, 2);
      dd = {(pick == 0) ? 8'hE1 : (pick == 1) ? 8'hE6 : 8'($urandom), 24'($urandom)};
      cycle($urandom_range(0, 1) == 1, cd, $urandom_range(0, 2) == 0, dd,
            $urandom_range(0, 3) == 0, 4'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule